// File: doc/BRIEF.md
# Stepped Reference Soft-Start Sequencer

This block produces the start-up ramp for the reference of a switching regulator. Once the block is enabled and sees a start pulse, it captures a 5-bit target code. It then raises a reference index from zero by one code at fixed intervals until the index equals the target. After that it holds the index and raises a ramp-done flag. A second timer runs alongside the ramp. It keeps a flag high that tells the power stage to halve its switch current limit for the opening few milliseconds.

Step and window lengths are counts of clock cycles. They are derived from a clock-frequency parameter, so the block can run from any system clock and a simulation can use a scaled clock. The index passes through a lookup to a millivolt value on a pseudo-logarithmic 32-entry scale. Full scale is 200 mV at code 31.

Top module: `ref_ramp_seq`

## Requirements
- R1: After reset, and while enable is low, refIndex, refMv, rampDone and halfLimit are all 0.
- R2: A start pulse sampled with enable high while idle captures targetCode. After that clock edge refIndex is 0, rampDone is 0 and halfLimit is 1.
- R3: During a ramp, refIndex rises by exactly one at each step boundary. Step boundaries fall every STEP_CYC = max(1, floor(CLK_HZ*213/1e6)) cycles after the start edge. refIndex never exceeds the captured target.
- R4: With target 31 the ramp has 32 steps. rampDone rises 32*STEP_CYC cycles after the start edge, with refIndex at 31.
- R5: With a target T below 31, refIndex stops at T. rampDone rises (T+1)*STEP_CYC cycles after the start edge and stays high, with refIndex held, while enable stays high.
- R6: halfLimit stays high for exactly WIN_CYC = max(1, floor(CLK_HZ*5/1000)) cycles from the start edge. It does not depend on when the ramp finishes.
- R7: Enable low clears refIndex, rampDone and halfLimit at the next clock edge, even mid-ramp. Start pulses while enable is low are ignored. Raising enable again leaves the block idle until a new start pulse.
- R8: Start pulses during a ramp or after ramp-done are ignored. Changes on targetCode after the start edge have no effect on the ramp.
- R9: refMv maps code c as follows: 0 for c=0, 2+3c for c=1..12, 38+6(c-12) for c=13..23, and 104+12(c-23) for c=24..31. So 5, 38, 104 and 200 mV fall at codes 1, 12, 23 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable level; low aborts and clears |
| startPulse | input | 1 | One-cycle request to begin a ramp |
| targetCode | input | 5 | Final reference code, captured at start |
| refIndex | output | 5 | Present reference code |
| refMv | output | 8 | Millivolt value of refIndex |
| rampDone | output | 1 | High once the index has dwelt one step at the target |
| halfLimit | output | 1 | High while the current limit must be halved |

## Verification
The bench runs a ramp for every one of the 32 target codes. Every cycle it compares the index, millivolt value, done flag and half-limit flag against values it computes from the step and window lengths. Small targets finish well inside the half-limit window and large ones outlast it, so the sweep shows that the two timers are independent. Extra start pulses and target changes in the middle of a ramp, pulses after done, pulses while disabled, and an enable drop partway through a ramp show that only a clean start begins a ramp and that disabling clears everything.

// File: rtl/ref_ramp_pkg.sv
package ref_ramp_pkg;

  parameter int CODE_W = 5;
  parameter int MV_W   = 8;

  typedef struct packed {
    logic clear;  // abort: index and target to zero
    logic load;   // start: capture target, index to zero
    logic step;   // step boundary reached
  } ramp_strb_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_DONE = 2'd2
  } ramp_state_t;

  // Piecewise reference scale: 3 mV, 6 mV, then 12 mV increments.
  function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] code);
    int c;
    int r;
    c = int'(code);
    if (c == 0)       r = 0;
    else if (c <= 12) r = 2 + 3 * c;
    else if (c <= 23) r = 38 + 6 * (c - 12);
    else              r = 104 + 12 * (c - 23);
    return MV_W'(r);
  endfunction

endpackage

// File: rtl/ref_ramp_ctrl.sv
module ref_ramp_ctrl
  import ref_ramp_pkg::*;
#(
  parameter int unsigned STEP_CYC = 21,
  parameter int unsigned WIN_CYC  = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       startPulse,
  input  logic       atTarget,
  output ramp_strb_t strb,
  output logic       rampDone,
  output logic       halfLimit
);

  localparam int STEP_W = $clog2(STEP_CYC + 1);
  localparam int WIN_W  = $clog2(WIN_CYC + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(WIN_CYC - 1);

  ramp_state_t       state;
  logic [STEP_W-1:0] stepCnt;
  logic [WIN_W-1:0]  winCnt;
  logic              startOk;
  logic              stepEnd;

  assign startOk = enable && startPulse && (state == ST_IDLE);
  assign stepEnd = (state == ST_RAMP) && (stepCnt == STEP_LAST);

  always_comb begin
    strb       = '0;
    strb.clear = !enable;
    strb.load  = startOk;
    strb.step  = enable && stepEnd;
  end

  assign rampDone = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state     <= ST_IDLE;
      stepCnt   <= '0;
      winCnt    <= '0;
      halfLimit <= 1'b0;
    end else if (startOk) begin
      state     <= ST_RAMP;
      stepCnt   <= '0;
      winCnt    <= '0;
      halfLimit <= 1'b1;
    end else begin
      if (state == ST_RAMP) begin
        if (stepEnd) begin
          stepCnt <= '0;
          if (atTarget) state <= ST_DONE;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
      if (halfLimit) begin
        if (winCnt == WIN_LAST) halfLimit <= 1'b0;
        else                    winCnt    <= winCnt + 1'b1;
      end
    end
  end

  // R7: disabling clears both flags one edge later
  a_r7_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rampDone && !halfLimit));

  // R5: done is sticky while enabled
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rampDone) |=> rampDone);

  // R8: a running ramp is never restarted or dropped to idle while enabled
  a_r8_ramp_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP && startPulse) |=> (state != ST_IDLE));

endmodule

// File: rtl/ref_ramp_dp.sv
module ref_ramp_dp
  import ref_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ramp_strb_t        strb,
  input  logic [CODE_W-1:0] targetCode,
  output logic [CODE_W-1:0] refIndex,
  output logic              atTarget
);

  logic [CODE_W-1:0] tgtReg;

  assign atTarget = (refIndex == tgtReg);

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clear) begin
      refIndex <= '0;
      tgtReg   <= '0;
    end else if (strb.load) begin
      refIndex <= '0;
      tgtReg   <= targetCode;
    end else if (strb.step && !atTarget) begin
      refIndex <= refIndex + 1'b1;
    end
  end

  // R3: index never overshoots the captured target
  a_r3_index_le_target: assert property (@(posedge clk) disable iff (!rst_n)
    refIndex <= tgtReg);

  // R3: index only moves by a single code upward or back to zero
  a_r3_unit_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (refIndex != $past(refIndex)) |->
      ((refIndex == $past(refIndex) + CODE_W'(1)) || (refIndex == '0)));

endmodule

// File: rtl/ref_ramp_seq.sv
module ref_ramp_seq
  import ref_ramp_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              startPulse,
  input  logic [CODE_W-1:0] targetCode,
  output logic [CODE_W-1:0] refIndex,
  output logic [MV_W-1:0]   refMv,
  output logic              rampDone,
  output logic              halfLimit
);

  localparam longint unsigned STEP_RAW = (longint'(CLK_HZ) * 213) / 1_000_000;
  localparam longint unsigned WIN_RAW  = (longint'(CLK_HZ) * 5) / 1_000;
  localparam int unsigned STEP_CYC = (STEP_RAW < 1) ? 1 : int'(STEP_RAW);
  localparam int unsigned WIN_CYC  = (WIN_RAW  < 1) ? 1 : int'(WIN_RAW);

  ramp_strb_t strb;
  logic       atTarget;

  ref_ramp_ctrl #(
    .STEP_CYC (STEP_CYC),
    .WIN_CYC  (WIN_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .startPulse (startPulse),
    .atTarget   (atTarget),
    .strb       (strb),
    .rampDone   (rampDone),
    .halfLimit  (halfLimit)
  );

  ref_ramp_dp u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .targetCode (targetCode),
    .refIndex   (refIndex),
    .atTarget   (atTarget)
  );

  assign refMv = code_to_mv(refIndex);

  // R5: index frozen once done has been held
  a_r5_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rampDone && $past(rampDone)) |-> $stable(refIndex));

  // R9: full-scale code always reads 200 mV
  a_r9_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (refIndex == '1) |-> (refMv == MV_W'(200)));

endmodule

// File: tb/tb_ref_ramp_seq.sv
`timescale 1ns/1ps
module tb_ref_ramp_seq;

  localparam int CLK_HZ = 100_000;
  localparam int STEP   = (CLK_HZ * 213) / 1_000_000;  // 21
  localparam int WIN    = (CLK_HZ * 5) / 1_000;        // 500

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       startPulse = 1'b0;
  logic [4:0] targetCode = '0;
  logic [4:0] refIndex;
  logic [7:0] refMv;
  logic       rampDone;
  logic       halfLimit;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ref_ramp_seq #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .startPulse(startPulse),
    .targetCode(targetCode), .refIndex(refIndex), .refMv(refMv),
    .rampDone(rampDone), .halfLimit(halfLimit)
  );

  function automatic int mvRef(input int code);
    int mv = 0;
    for (int c = 1; c <= code; c++) begin
      if (c == 1)       mv += 5;
      else if (c <= 12) mv += 3;
      else if (c <= 23) mv += 6;
      else              mv += 12;
    end
    return mv;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdle(input string tag);
    chk({tag, " index"}, int'(refIndex), 0);
    chk({tag, " mv"}, int'(refMv), 0);
    chk({tag, " done"}, int'(rampDone), 0);
    chk({tag, " half"}, int'(halfLimit), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic runTarget(input int t);
    int last;
    int expIdx;
    @(negedge clk);
    startPulse = 1'b1;
    targetCode = 5'(t);
    @(negedge clk);
    startPulse = 1'b0;
    targetCode = ~5'(t);                         // R8: late target change
    chk("R2 start index", int'(refIndex), 0);
    chk("R2 start half", int'(halfLimit), 1);
    chk("R2 start done", int'(rampDone), 0);
    last = ((t + 1) * STEP > WIN ? (t + 1) * STEP : WIN) + 3;
    for (int m = 0; m <= last; m++) begin
      if (m > 0) @(negedge clk);
      expIdx = (m / STEP < t) ? m / STEP : t;
      chk("R3 index", int'(refIndex), expIdx);
      chk(t == 31 ? "R4 done" : "R5 done", int'(rampDone), (m >= (t + 1) * STEP) ? 1 : 0);
      chk("R6 halfLimit", int'(halfLimit), (m < WIN) ? 1 : 0);
      chk("R9 mv", int'(refMv), mvRef(expIdx));
      if (m == 5) begin                          // R8: restart attempt mid-ramp
        startPulse = 1'b1;
        targetCode = 5'(31 - t);
      end else if (m == 6) begin
        startPulse = 1'b0;
      end
    end
    startPulse = 1'b1;                           // R8: pulse after done
    @(negedge clk);
    startPulse = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 after-done index", int'(refIndex), t);
      chk("R8 after-done done", int'(rampDone), 1);
    end
    enable = 1'b0;                               // R7: disable plus ignored start
    startPulse = 1'b1;
    @(negedge clk);
    chkIdle("R7 disabled");
    @(negedge clk);
    startPulse = 1'b0;
    chkIdle("R7 start while disabled");
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chkIdle("R7 re-enabled idle");
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chkIdle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chkIdle("R1 after reset");
    enable = 1'b1;
    @(negedge clk);
    chkIdle("R1 enabled no start");

    for (int t = 0; t < 32; t++) runTarget(t);

    // R7: abort partway through a ramp
    @(negedge clk);
    startPulse = 1'b1;
    targetCode = 5'd20;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (50) @(negedge clk);
    chk("R7 mid-ramp index", int'(refIndex), 50 / STEP);
    chk("R7 mid-ramp half", int'(halfLimit), 1);
    enable = 1'b0;
    @(negedge clk);
    chkIdle("R7 abort");
    enable = 1'b1;
    repeat (30) @(negedge clk);
    chkIdle("R7 no auto restart");

    summary();
  end

endmodule